// File: doc/BRIEF.md
# Pen Plotter Step Sequencer

The block takes 18-bit command words for an incremental pen plotter and turns them into single-cycle step pulses. Each word packs three 6-bit step fields. Every field can raise or lower the pen and step the carriage by one increment in X and in Y, in either direction. The fields are issued one at a time with the least significant field first. A word ends early at the first all-zero field.

A pacing counter keeps issued steps at least one step interval apart. The interval is derived from the clock frequency and the plotter's maximum step rate. A field that asks for two opposing actions is refused: it raises a one-cycle error and the block moves on.

One active word and one held word can be occupied at the same time, so a new word can be accepted while the current one is still being stepped. `cmd_ready` tells the host when a word can be taken.

Top module: `plot_seq_top`

## Requirements
- R1: After reset `cmd_ready` is 1, and every step output and `combo_err` is 0.
- R2: Fields are issued in this order: `cmd_word[5:0]`, then `cmd_word[11:6]`, then `cmd_word[17:12]`.
- R3: Within a field, bit 5 drives `pen_up`, bit 4 drives `pen_down`, bit 3 drives `x_pos`, bit 2 drives `x_neg`, bit 1 drives `y_pos` and bit 0 drives `y_neg`. A legal field shows its bits on these outputs for exactly one cycle.
- R4: When the current field is all-zero, the word ends there. Its remaining fields are discarded and no pulse is emitted for the zero field.
- R5: A field counts as illegal when it sets both bits 5 and 4, both bits 3 and 2, or both bits 1 and 0. An illegal field pulses `combo_err` for one cycle and emits no step pulses. The next field is evaluated on the following clock edge, without waiting for the step interval.
- R6: Two step pulses are never closer than INTERVAL = CLK_HZ/STEP_HZ cycles. When legal fields follow one another, their pulses are exactly INTERVAL cycles apart.
- R7: When the pacer is idle, the first field of an accepted word is evaluated on the edge after the accepting edge. Its result is visible in the cycle that follows that evaluation edge.
- R8: A word is accepted on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 only while an active word and a held word are both present. Words are executed in the order they were accepted.
- R9: A `cmd_valid` presented while `cmd_ready` is 0 is ignored. That word never produces a step.
- R10: A word whose fields are all zero produces no pulse and no error, and it frees the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a command word |
| cmd_word | input | 18 | Three 6-bit step fields, least significant field first |
| cmd_ready | output | 1 | A word offered now will be accepted |
| pen_up | output | 1 | One-cycle pen raise pulse |
| pen_down | output | 1 | One-cycle pen lower pulse |
| x_pos | output | 1 | One-cycle +X step pulse |
| x_neg | output | 1 | One-cycle -X step pulse |
| y_pos | output | 1 | One-cycle +Y step pulse |
| y_neg | output | 1 | One-cycle -Y step pulse |
| combo_err | output | 1 | One-cycle pulse for a field with opposing requests |

## Verification
Each field outcome, whether a step pulse, an error or nothing, is registered. It therefore appears in the cycle after the edge that evaluates the field. That edge is the one after acceptance when the pacer is idle, and otherwise the edge after the pacer count reaches zero. `cmd_ready` changes on the edge that fills or drains the second slot. The bench keeps a cycle-level reference that updates on the rising edge from the same inputs, and it compares every output on the falling edge, when both sides have settled for the same cycle. Directed cases measure pulse spacing in cycles from a cycle counter, including the single-cycle gap from an error to the following step.

// File: rtl/plot_seq_pkg.sv
package plot_seq_pkg;

    localparam int FIELD_W    = 6;
    localparam int NUM_FIELDS = 3;
    localparam int WORD_W     = FIELD_W * NUM_FIELDS;
    localparam int IDX_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;
    localparam int NUM_PAIRS  = FIELD_W / 2;

    // Field layout, most significant member first.
    typedef struct packed {
        logic pen_up;
        logic pen_down;
        logic x_pos;
        logic x_neg;
        logic y_pos;
        logic y_neg;
    } step_t;

endpackage

// File: rtl/plot_field_decode.sv
module plot_field_decode
    import plot_seq_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output step_t              step,
    output logic               empty,
    output logic               conflict
);

    logic [NUM_PAIRS-1:0] pair_hit;

    // Each adjacent bit pair is one opposing couple.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign pair_hit[g] = field[2*g] & field[2*g+1];
    end

    always_comb begin
        step     = step_t'(field);
        empty    = (field == '0);
        conflict = |pair_hit;
    end

endmodule

// File: rtl/plot_pacer.sv
module plot_pacer #(
    parameter int INTERVAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic idle
);

    localparam int CW     = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int RELOAD = INTERVAL - 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire) begin
            cnt_d = CW'(RELOAD);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);

    // R6: no new step may be issued while a previous interval is still running.
    p_fire_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cnt_q == '0));

endmodule

// File: rtl/plot_word_queue.sv
module plot_word_queue
    import plot_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               advance,
    input  logic               finish,
    output logic               ready,
    output logic               act_valid,
    output logic [FIELD_W-1:0] cur_field,
    output logic               last_field
);

    typedef struct packed {
        logic              act_valid;
        logic [WORD_W-1:0] act_word;
        logic [IDX_W-1:0]  act_idx;
        logic              hold_valid;
        logic [WORD_W-1:0] hold_word;
    } qstate_t;

    qstate_t q_d, q_q;
    logic    accept;
    logic    act_free;

    assign ready = !(q_q.hold_valid && q_q.act_valid);

    always_comb begin
        q_d      = q_q;
        accept   = in_valid && ready;
        act_free = !q_q.act_valid || finish;

        if (finish) begin
            q_d.act_valid = 1'b0;
        end else if (advance) begin
            q_d.act_word = q_q.act_word >> FIELD_W;
            q_d.act_idx  = q_q.act_idx + IDX_W'(1);
        end

        if (act_free) begin
            if (q_q.hold_valid) begin
                q_d.act_valid  = 1'b1;
                q_d.act_word   = q_q.hold_word;
                q_d.act_idx    = '0;
                q_d.hold_valid = 1'b0;
                if (accept) begin
                    q_d.hold_valid = 1'b1;
                    q_d.hold_word  = in_word;
                end
            end else if (accept) begin
                q_d.act_valid = 1'b1;
                q_d.act_word  = in_word;
                q_d.act_idx   = '0;
            end
        end else if (accept) begin
            q_d.hold_valid = 1'b1;
            q_d.hold_word  = in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign act_valid  = q_q.act_valid;
    assign cur_field  = q_q.act_word[FIELD_W-1:0];
    assign last_field = (q_q.act_idx == IDX_W'(NUM_FIELDS - 1));

    // R9: a refused offer leaves the held word untouched.
    p_full_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(q_q.hold_word));

    // R8: when a word finishes, the held word becomes the active one.
    p_in_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && q_q.hold_valid) |=> (q_q.act_valid && q_q.act_word == $past(q_q.hold_word)));

    // R8: a held word stays in place until the active word ends.
    p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.hold_valid && q_q.act_valid && !finish) |=> (q_q.hold_valid && $stable(q_q.hold_word)));

endmodule

// File: rtl/plot_seq_top.sv
module plot_seq_top
    import plot_seq_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int STEP_HZ = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_ready,
    output logic              pen_up,
    output logic              pen_down,
    output logic              x_pos,
    output logic              x_neg,
    output logic              y_pos,
    output logic              y_neg,
    output logic              combo_err
);

    localparam int RATIO    = CLK_HZ / STEP_HZ;
    localparam int INTERVAL = (RATIO < 1) ? 1 : RATIO;

    typedef struct packed {
        step_t step;
        logic  err;
    } out_t;

    out_t               out_d, out_q;
    logic               act_valid;
    logic [FIELD_W-1:0] cur_field;
    logic               last_field;
    logic               pace_idle;
    step_t              dec_step;
    logic               dec_empty;
    logic               dec_conflict;
    logic               eval;
    logic               fire;
    logic               advance;
    logic               finish;

    plot_word_queue i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (cmd_valid),
        .in_word    (cmd_word),
        .advance    (advance),
        .finish     (finish),
        .ready      (cmd_ready),
        .act_valid  (act_valid),
        .cur_field  (cur_field),
        .last_field (last_field)
    );

    plot_field_decode i_decode (
        .field    (cur_field),
        .step     (dec_step),
        .empty    (dec_empty),
        .conflict (dec_conflict)
    );

    plot_pacer #(.INTERVAL(INTERVAL)) i_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .idle  (pace_idle)
    );

    always_comb begin
        eval    = act_valid && pace_idle;
        finish  = eval && (dec_empty || last_field);
        advance = eval && !dec_empty && !last_field;
        fire    = eval && !dec_empty && !dec_conflict;

        out_d      = '0;
        out_d.step = fire ? dec_step : '0;
        out_d.err  = eval && !dec_empty && dec_conflict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pen_up    = out_q.step.pen_up;
    assign pen_down  = out_q.step.pen_down;
    assign x_pos     = out_q.step.x_pos;
    assign x_neg     = out_q.step.x_neg;
    assign y_pos     = out_q.step.y_pos;
    assign y_neg     = out_q.step.y_neg;
    assign combo_err = out_q.err;

    // R5: opposing pulses never appear together.
    p_pen_pair_r5: assert property (@(posedge clk) disable iff (!rst_n) !(pen_up && pen_down));
    p_x_pair_r5:   assert property (@(posedge clk) disable iff (!rst_n) !(x_pos && x_neg));
    p_y_pair_r5:   assert property (@(posedge clk) disable iff (!rst_n) !(y_pos && y_neg));

    // R5: a refused field produces no step pulse.
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        combo_err |-> (out_q.step == '0));

    // R6: while a step pulse is shown, the pacer is counting.
    if (INTERVAL > 1) begin : g_spacing
        p_step_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.step != '0) |-> !pace_idle);
    end

endmodule

// File: tb/test_plot_seq_top.sv
`timescale 1ns/1ps
module test_plot_seq_top;

    localparam int CLK_HZ   = 2400;
    localparam int STEP_HZ  = 300;
    localparam int INTERVAL = CLK_HZ / STEP_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [17:0] cmd_word = '0;
    logic        cmd_ready;
    logic        pen_up, pen_down, x_pos, x_neg, y_pos, y_neg, combo_err;

    always #4 clk = ~clk;

    plot_seq_top #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ)) i_plot_seq_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .pen_up(pen_up), .pen_down(pen_down),
        .x_pos(x_pos), .x_neg(x_neg), .y_pos(y_pos), .y_neg(y_neg),
        .combo_err(combo_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model, advanced on the rising edge.
    bit        ma_v, mh_v;
    bit [17:0] ma_w, mh_w;
    int        ma_i;
    int        m_cnt;
    bit [5:0]  exp_vec;
    bit        exp_err;
    bit [5:0]  m_fld;
    bit        m_acc, m_fin, m_free;

    always @(posedge clk) begin
        if (!rst_n) begin
            ma_v = 0; mh_v = 0; ma_w = 0; mh_w = 0; ma_i = 0; m_cnt = 0;
            exp_vec = 0; exp_err = 0;
        end else begin
            m_acc   = cmd_valid && !(mh_v && ma_v);
            m_fld   = 6'((ma_w >> (6 * ma_i)) & 18'h3f);
            m_fin   = 0;
            exp_vec = 0;
            exp_err = 0;
            if (ma_v && m_cnt == 0) begin
                if (m_fld == 0) begin
                    m_fin = 1;
                end else begin
                    if ((m_fld[5] && m_fld[4]) || (m_fld[3] && m_fld[2]) || (m_fld[1] && m_fld[0]))
                        exp_err = 1;
                    else begin
                        exp_vec = m_fld;
                        m_cnt   = INTERVAL;
                    end
                    if (ma_i == 2) m_fin = 1;
                    else ma_i = ma_i + 1;
                end
            end
            if (m_cnt > 0 && exp_vec == 0) m_cnt = m_cnt - 1;
            else if (exp_vec != 0) m_cnt = INTERVAL - 1;
            m_free = !ma_v || m_fin;
            if (m_fin) ma_v = 0;
            if (m_free) begin
                if (mh_v) begin
                    ma_v = 1; ma_w = mh_w; ma_i = 0; mh_v = 0;
                    if (m_acc) begin mh_v = 1; mh_w = cmd_word; end
                end else if (m_acc) begin
                    ma_v = 1; ma_w = cmd_word; ma_i = 0;
                end
            end else if (m_acc) begin
                mh_v = 1; mh_w = cmd_word;
            end
        end
    end

    // Falling-edge monitor: compare and log.
    int       cyc = 0;
    bit [5:0] cap_vec [16];
    int       cap_cyc [16];
    int       cap_n = 0;
    int       err_cyc = -1;
    int       err_n = 0;
    int       low_seen = 0;
    logic [5:0] dut_vec;

    assign dut_vec = {pen_up, pen_down, x_pos, x_neg, y_pos, y_neg};

    always @(negedge clk) begin
        cyc++;
        if (chk_en) begin
            check(dut_vec == exp_vec, "R2 R3 R4 R6 R7 step outputs", int'(dut_vec), int'(exp_vec));
            check(combo_err == exp_err, "R5 combo_err", int'(combo_err), int'(exp_err));
            check(cmd_ready == !(mh_v && ma_v), "R8 R9 cmd_ready", int'(cmd_ready), int'(!(mh_v && ma_v)));
            if (dut_vec != 0 && cap_n < 16) begin
                cap_vec[cap_n] = dut_vec;
                cap_cyc[cap_n] = cyc;
                cap_n++;
            end
            if (combo_err) begin err_cyc = cyc; err_n++; end
            if (!cmd_ready) low_seen++;
        end
    end

    task automatic clear_log();
        cap_n = 0; err_n = 0; err_cyc = -1; low_seen = 0;
    endtask

    task automatic send(input logic [17:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [5:0] make_field();
        int r = int'($urandom % 8);
        logic [1:0] p, x, y;
        if (r == 0) return 6'h00;
        if (r == 1) begin
            case ($urandom % 3)
                0: return 6'h30 | 6'($urandom % 16);
                1: return 6'h0c | 6'($urandom % 4);
                default: return 6'h03 | 6'($urandom % 4) << 2;
            endcase
        end
        p = 2'($urandom % 3); x = 2'($urandom % 3); y = 2'($urandom % 3);
        return {p, x, y};
    endfunction

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        check(dut_vec == 0 && combo_err == 0, "R1 outputs quiet after reset", int'({dut_vec, combo_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;

        // R10: all-zero word
        clear_log();
        send(18'h0);
        idle(20);
        check(cap_n == 0 && err_n == 0, "R10 zero word silent", cap_n + err_n, 0);
        check(cmd_ready == 1'b1, "R10 ready after zero word", int'(cmd_ready), 1);

        // R2 R3 R6: three legal fields, order and spacing
        clear_log();
        send({6'h24, 6'h11, 6'h0a});
        idle(3 * INTERVAL + 5);
        check(cap_n == 3, "R2 three pulses", cap_n, 3);
        check(cap_vec[0] == 6'h0a, "R2 R3 first field", int'(cap_vec[0]), 'h0a);
        check(cap_vec[1] == 6'h11, "R2 R3 second field", int'(cap_vec[1]), 'h11);
        check(cap_vec[2] == 6'h24, "R2 R3 third field", int'(cap_vec[2]), 'h24);
        check(cap_cyc[1] - cap_cyc[0] == INTERVAL, "R6 spacing", cap_cyc[1] - cap_cyc[0], INTERVAL);
        check(cap_cyc[2] - cap_cyc[1] == INTERVAL, "R6 spacing again", cap_cyc[2] - cap_cyc[1], INTERVAL);

        // R5: illegal field then legal field on the next edge
        clear_log();
        send({6'h00, 6'h08, 6'h0c});
        idle(2 * INTERVAL + 5);
        check(err_n == 1, "R5 one error pulse", err_n, 1);
        check(cap_n == 1 && cap_vec[0] == 6'h08, "R5 next field issued", int'(cap_vec[0]), 'h08);
        check(cap_cyc[0] - err_cyc == 1, "R5 no wait after error", cap_cyc[0] - err_cyc, 1);

        // R4: zero middle field ends the word
        clear_log();
        send({6'h04, 6'h00, 6'h08});
        idle(3 * INTERVAL + 5);
        check(cap_n == 1, "R4 stop at zero field", cap_n, 1);

        // R8 R9: queue order, full refusal
        clear_log();
        send(18'h01);
        send(18'h02);
        #1;
        check(cmd_ready == 1'b0, "R8 ready low when both slots full", int'(cmd_ready), 0);
        cmd_valid = 1'b1; cmd_word = 18'h20;
        @(negedge clk);
        cmd_valid = 1'b0;
        send(18'h04);
        idle(4 * INTERVAL + 5);
        check(cap_n == 3, "R9 refused word dropped", cap_n, 3);
        check(cap_vec[0] == 6'h01 && cap_vec[1] == 6'h02 && cap_vec[2] == 6'h04,
              "R8 execution order", int'({cap_vec[0], cap_vec[1], cap_vec[2]}), 'h01084);
        check(low_seen > 0, "R8 ready dropped", low_seen, 1);

        // Random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cmd_valid = ($urandom % 3) == 0;
            cmd_word  = {make_field(), make_field(), make_field()};
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        idle(4 * INTERVAL * 3);

        summary();
        $finish;
    end

endmodule